// File: doc/BRIEF.md
# Reassociating Vector Sum Reducer

This block adds up an integer stream of any length. The stream arrives as chunks of `LANES` elements at a time. It does not feed one running accumulator. It keeps `LANES` independent partial sums in a register and adds each incoming chunk into them lane by lane. Each lane's addition therefore sits on its own short carry path, whatever the stream length.

The chunk marked last closes the stream. The block then folds the register down to one value over `log2(LANES)` cycles. In each fold cycle, the upper half of the still-active partials is added into the lower half, and the active length is halved. The final remaining partial is the result. It is presented for one cycle, and the register starts again from zero for the next stream.

A stream of N elements is sent as full chunks followed by a last chunk. The last chunk carries a lane count, normally N mod `LANES`. Lanes at or above that count are treated as zero, whatever their data holds.

Top module: `vred_sum`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` and `busy` are low, and the partial sums are zero.
- R2: An accepted chunk with `in_count` >= `LANES` adds each lane into its own partial sum. Lane i occupies bits `[i*W +: W]` of `in_data`. The final result equals the sum of every accepted element.
- R3: In an accepted chunk, lane i contributes zero whenever i >= `in_count`. An `in_count` of 0 therefore adds nothing.
- R4: A chunk is accepted when `in_valid` is high and `busy` is low. Once a chunk with `in_last` high is accepted, `busy` is high for exactly `log2(LANES)` cycles. `out_valid` is then high for exactly one cycle, in the cycle right after `busy` falls, and is low otherwise.
- R5: All sums wrap modulo 2^W, and `out_sum` is W bits wide.
- R6: Chunks offered while `busy` is high are ignored and do not affect any result.
- R7: After a result is produced, the partial sums start from zero, so the next stream's result covers only its own chunks.
- R8: A stream of a single chunk, flagged last, produces the sum of that chunk's counted lanes.
- R9: Cycles with `in_valid` low change nothing, whatever `in_data`, `in_count` and `in_last` hold. `out_sum` changes only in a cycle where `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Chunk present on `in_data` |
| in_last | input | 1 | This chunk ends the stream |
| in_count | input | $clog2(LANES+1) | Number of lanes counted, from lane 0 upward |
| in_data | input | LANES*W | Chunk elements, lane i at bits [i*W +: W] |
| busy | output | 1 | Fold in progress; input is ignored |
| out_valid | output | 1 | One-cycle result strobe |
| out_sum | output | W | Reduced sum, held until the next result |

## Verification
A corrupted partial-sum lane can hide during accumulation. It shows only in `out_sum` at the end of the stream, `log2(LANES)` cycles after the last chunk. Comparing every result against an arithmetic total therefore catches it within one stream. A wrong fold step count or fold-half selection shows in the same result. It also shows as a `busy` window of the wrong length, which is visible the moment `out_valid` rises. A failure to clear between streams shows as a stale offset in the first result of the following stream. The sweep covers every remainder count and several stream lengths, so each lane and each masking decision reaches the output.

// File: rtl/vred_pkg.sv
package vred_pkg;

    typedef enum logic {
        ST_ACCUM = 1'b0,
        ST_FOLD  = 1'b1
    } vred_state_e;

endpackage

// File: rtl/vred_lane_acc.sv
module vred_lane_acc #(
    parameter int LANES = 8,
    parameter int W     = 16,
    parameter int CW    = $clog2(LANES + 1)
) (
    input  logic [LANES*W-1:0] acc_in,
    input  logic [LANES*W-1:0] din,
    input  logic [CW-1:0]      count,
    output logic [LANES*W-1:0] acc_out
);

    // One independent adder per lane; lanes at or above count add zero.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [W-1:0] addend;
        assign addend = (CW'(i) < count) ? din[i*W +: W] : '0;
        assign acc_out[i*W +: W] = acc_in[i*W +: W] + addend;
    end

endmodule

// File: rtl/vred_fold.sv
module vred_fold #(
    parameter int LANES = 8,
    parameter int W     = 16,
    parameter int CW    = $clog2(LANES + 1)
) (
    input  logic [LANES*W-1:0] vec_in,
    input  logic [CW-1:0]      half,
    output logic [LANES*W-1:0] vec_out
);

    // Lane i below half absorbs lane i+half; everything else is cleared.
    always_comb begin
        vec_out = '0;
        for (int i = 0; i < LANES / 2; i++) begin
            if (CW'(i) < half) begin
                vec_out[i*W +: W] = vec_in[i*W +: W]
                                  + vec_in[(i + int'(half))*W +: W];
            end
        end
    end

endmodule

// File: rtl/vred_sum.sv
module vred_sum #(
    parameter int LANES = 8,
    parameter int W     = 16,
    parameter int CW    = $clog2(LANES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_last,
    input  logic [CW-1:0]      in_count,
    input  logic [LANES*W-1:0] in_data,
    output logic               busy,
    output logic               out_valid,
    output logic [W-1:0]       out_sum
);
    import vred_pkg::*;

    localparam logic [CW-1:0] HALF_INIT = CW'(LANES / 2);

    typedef struct packed {
        vred_state_e        st;
        logic [LANES*W-1:0] part;
        logic [CW-1:0]      half;
        logic               ovld;
        logic [W-1:0]       sum;
    } vred_regs_t;

    vred_regs_t r_q, r_d;

    logic [LANES*W-1:0] acc_sum;
    logic [LANES*W-1:0] fold_sum;

    vred_lane_acc #(.LANES(LANES), .W(W), .CW(CW)) u_acc (
        .acc_in  (r_q.part),
        .din     (in_data),
        .count   (in_count),
        .acc_out (acc_sum)
    );

    vred_fold #(.LANES(LANES), .W(W), .CW(CW)) u_fold (
        .vec_in  (r_q.part),
        .half    (r_q.half),
        .vec_out (fold_sum)
    );

    always_comb begin
        r_d      = r_q;
        r_d.ovld = 1'b0;
        unique case (r_q.st)
            ST_ACCUM: begin
                if (in_valid) begin
                    r_d.part = acc_sum;
                    if (in_last) begin
                        r_d.st   = ST_FOLD;
                        r_d.half = HALF_INIT;
                    end
                end
            end
            ST_FOLD: begin
                if (r_q.half == CW'(1)) begin
                    r_d.sum  = fold_sum[W-1:0];
                    r_d.ovld = 1'b1;
                    r_d.part = '0;
                    r_d.st   = ST_ACCUM;
                end else begin
                    r_d.part = fold_sum;
                    r_d.half = r_q.half >> 1;
                end
            end
            default: r_d.st = ST_ACCUM;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_ACCUM;
            r_q.part <= '0;
            r_q.half <= '0;
            r_q.ovld <= 1'b0;
            r_q.sum  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st == ST_FOLD);
    assign out_valid = r_q.ovld;
    assign out_sum   = r_q.sum;

endmodule

// File: rtl/vred_sum_chk.sv
module vred_sum_chk #(
    parameter int LANES = 8,
    parameter int W     = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         in_last,
    input logic         busy,
    input logic         out_valid,
    input logic [W-1:0] out_sum
);
    localparam int FOLDS = $clog2(LANES);
    localparam int NW    = $clog2(LANES) + 2;

    // Length of the current or just-ended busy window.
    logic [NW-1:0] busy_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_len_q <= '0;
        else if (busy) busy_len_q <= busy_len_q + 1'b1;
        else           busy_len_q <= '0;
    end

    a_r4_fold_length: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (busy_len_q == NW'(FOLDS)));

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    a_r4_enter_fold: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last && !busy) |=> busy);

    a_r6_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !out_valid);

    a_r9_sum_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_sum) |-> out_valid);

    a_r1_result_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(busy));

endmodule

bind vred_sum vred_sum_chk #(.LANES(LANES), .W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .busy      (busy),
    .out_valid (out_valid),
    .out_sum   (out_sum)
);

// File: tb/vred_sum_test.sv
module vred_sum_test;
    localparam int LANES = 4;
    localparam int W     = 8;
    localparam int CW    = $clog2(LANES + 1);
    localparam int FOLDS = $clog2(LANES);

    logic               clk = 1'b0;
    logic               rst_n;
    logic               in_valid;
    logic               in_last;
    logic [CW-1:0]      in_count;
    logic [LANES*W-1:0] in_data;
    logic               busy;
    logic               out_valid;
    logic [W-1:0]       out_sum;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    vred_sum #(.LANES(LANES), .W(W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_count  (in_count),
        .in_data   (in_data),
        .busy      (busy),
        .out_valid (out_valid),
        .out_sum   (out_sum)
    );

    task automatic check_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [LANES*W-1:0] rand_chunk();
        logic [LANES*W-1:0] v;
        for (int l = 0; l < LANES; l++) v[l*W +: W] = W'($urandom);
        return v;
    endfunction

    // Send one stream; the last chunk carries lastcnt lanes.
    task automatic run_stream(int nchunks, int lastcnt, int gap, bit junk,
                              bit allmax, string req);
        logic [W-1:0] exp_sum = '0;
        for (int c = 0; c < nchunks; c++) begin
            int cnt = (c == nchunks - 1) ? lastcnt : LANES;
            logic [LANES*W-1:0] chunk = rand_chunk();
            if (allmax) chunk = '1;
            for (int l = 0; l < LANES; l++)
                if (l < cnt) exp_sum = exp_sum + chunk[l*W +: W];
            @(negedge clk);
            in_valid = 1'b1;
            in_last  = (c == nchunks - 1);
            in_count = CW'(cnt);
            in_data  = chunk;
            if (gap > 0 && c != nchunks - 1) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    in_valid = 1'b0;   // R9: idle cycles with garbage
                    in_last  = 1'b1;
                    in_count = CW'(LANES);
                    in_data  = rand_chunk();
                end
            end
        end
        for (int k = 0; k < FOLDS; k++) begin
            @(negedge clk);
            check_eq("R4", "busy during fold", int'(busy), 1);
            check_eq("R4", "out_valid during fold", int'(out_valid), 0);
            in_valid = junk;           // R6: offered while busy
            in_last  = junk;
            in_count = CW'(LANES);
            in_data  = rand_chunk();
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        check_eq("R4", "out_valid after fold", int'(out_valid), 1);
        check_eq("R4", "busy after fold", int'(busy), 0);
        check_eq(req, "out_sum", int'(out_sum), int'(exp_sum));
        @(negedge clk);
        check_eq("R4", "out_valid pulse ends", int'(out_valid), 0);
        check_eq("R9", "out_sum held", int'(out_sum), int'(exp_sum));
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_last  = 1'b0;
        in_count = '0;
        in_data  = '0;
        repeat (3) @(negedge clk);
        check_eq("R1", "out_valid in reset", int'(out_valid), 0);
        check_eq("R1", "busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", "out_valid after reset", int'(out_valid), 0);
        check_eq("R1", "busy after reset", int'(busy), 0);

        // R2, R3, R8: every stream length up to 4 and every remainder count
        for (int n = 1; n <= 4; n++)
            for (int lc = 0; lc <= LANES; lc++)
                run_stream(n, lc, 0, 1'b0, 1'b0,
                           (n == 1) ? "R8" : ((lc < LANES) ? "R3" : "R2"));

        // R6: junk chunks offered throughout each fold
        for (int n = 1; n <= 3; n++)
            run_stream(n, LANES, 0, 1'b1, 1'b0, "R6");

        // R7: back-to-back streams; each must start from zero
        run_stream(2, LANES, 0, 1'b0, 1'b1, "R7");
        run_stream(1, 1, 0, 1'b0, 1'b0, "R7");

        // R9: idle cycles between chunks
        run_stream(3, 2, 2, 1'b0, 1'b0, "R9");
        run_stream(4, LANES, 1, 1'b0, 1'b0, "R9");

        // R5: all-ones elements force wraparound
        run_stream(5, LANES, 0, 1'b0, 1'b1, "R5");
        run_stream(9, 3, 0, 1'b0, 1'b1, "R5");

        finish_run();
    end

endmodule